// File: doc/BRIEF.md
# MLC Refresh-Mode Decision Unit

This block chooses how a worn multi-level-cell flash page is refreshed. Each cell holds two bits and sits at one of four threshold-voltage levels. During a refresh the page is read out and passed through error correction. The raw symbols and the corrected symbols then reach this unit side by side, as two valid/ready streams that each carry `LANES` cells per beat. The unit compares the raw level and the corrected level of every cell.

A cell whose raw level sits above its corrected level has been pushed up by program interference; this is a right shift. A cell whose raw level sits below its corrected level has lost charge over time; this is a left shift. The unit keeps a separate running count of each kind across the page. A reprogram in place can only add charge. It therefore fixes left shifts but leaves right shifts behind, and those pile up over repeated refreshes.

When the last beat is accepted, the unit compares the right-shift count with a programmable limit. It then reports one of two choices: write the corrected data back in place, or move the page to a fresh location. The choice is held until it is acknowledged. While the choice is unacknowledged, both input streams are stalled.

Top module: `mlc_refresh_judge`

## Requirements
- R1: Each 2-bit cell code maps to a voltage level as follows: code 11 is level 0, code 10 is level 1, code 01 is level 2 and code 00 is level 3. A cell whose raw level is above its corrected level adds one to `rightCount`.
- R2: A cell whose raw level is below its corrected level adds one to `leftCount`. A cell whose two codes are equal changes neither count.
- R3: Both counts saturate at 2^CNT_W-1 and never wrap.
- R4: A `startPage` pulse clears both counts. If a beat is accepted in the same cycle, the new counts equal that beat's contribution alone.
- R5: A beat is accepted only in a cycle where both `rawValid` and `corValid` are high and no decision is pending. `rawReady` equals `corValid` and no pending decision. `corReady` equals `rawValid` and no pending decision.
- R6: `done` is high for exactly one cycle, in the cycle after the beat with `rawLast` set is accepted. `decisionValid` rises in that same cycle and stays high until an edge at which `ackDecision` is high.
- R7: `remap` is 1 when the right-shift count, including the last beat, is at least the `threshold` value present when that beat is accepted. Otherwise `remap` is 0. The left-shift count has no influence on `remap`.
- R8: While `decisionValid` is high, both ready outputs are low, and both counts and `remap` stay unchanged.
- R9: After reset, both counts are 0 and `done`, `decisionValid` and `remap` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPage | input | 1 | Clears both shift counts at the start of a page |
| rawValid | input | 1 | Raw beat valid |
| rawReady | output | 1 | Raw beat ready |
| rawLast | input | 1 | Raw beat is the last beat of the page |
| rawData | input | 2*LANES | Raw cell codes; cell i occupies bits [2i+1:2i] |
| corValid | input | 1 | Corrected beat valid |
| corReady | output | 1 | Corrected beat ready |
| corData | input | 2*LANES | Corrected cell codes, laid out like rawData |
| threshold | input | CNT_W | Right-shift limit at or above which the page is moved |
| ackDecision | input | 1 | Acknowledges the held decision |
| done | output | 1 | One-cycle strobe that marks a new decision |
| decisionValid | output | 1 | A decision is held and unacknowledged |
| remap | output | 1 | 1 = move the page, 0 = reprogram in place |
| rightCount | output | CNT_W | Right-shift cells counted in the current page |
| leftCount | output | CNT_W | Left-shift cells counted in the current page |

## Verification
The bench builds the unit with `LANES`=4 and `CNT_W`=6. With a ceiling of 63, a directed page of twenty beats in which every cell is right-shifted drives the counts into saturation, and the threshold can then be set exactly at the ceiling. With four lanes, a single beat can carry a right shift, a left shift, an equal cell and a level-adjacent pair together. Short random pages with random thresholds land on both sides of the limit.

// File: rtl/mlc_refresh_pkg.sv
package mlc_refresh_pkg;

  typedef struct packed {
    logic clear;   // start of page: counts restart from zero
    logic accept;  // a symbol pair is consumed this cycle
    logic last;    // the consumed pair closes the page
  } judge_ctrl_t;

  // threshold-voltage rank of a 2-bit cell code, lowest charge first
  function automatic logic [1:0] cellLevel(input logic [1:0] code);
    case (code)
      2'b11:   cellLevel = 2'd0;
      2'b10:   cellLevel = 2'd1;
      2'b01:   cellLevel = 2'd2;
      default: cellLevel = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/mlc_shift_datapath.sv
module mlc_shift_datapath
  import mlc_refresh_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CNT_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  judge_ctrl_t          ctrl,
  input  logic [2*LANES-1:0]   rawData,
  input  logic [2*LANES-1:0]   corData,
  input  logic [CNT_W-1:0]     threshold,
  output logic [CNT_W-1:0]     rightCount,
  output logic [CNT_W-1:0]     leftCount,
  output logic                 remap
);
  localparam int SUM_W = $clog2(LANES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [LANES-1:0] rightBit, leftBit;
  logic [SUM_W-1:0] rightBeat, leftBeat;
  logic [CNT_W-1:0] rightBase, leftBase, rightNext, leftNext;

  // per-cell shift direction
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [1:0] rawLvl, corLvl;
    assign rawLvl      = cellLevel(rawData[2*g +: 2]);
    assign corLvl      = cellLevel(corData[2*g +: 2]);
    assign rightBit[g] = rawLvl > corLvl;
    assign leftBit[g]  = rawLvl < corLvl;
  end

  always_comb begin
    rightBeat = '0;
    leftBeat  = '0;
    for (int i = 0; i < LANES; i++) begin
      rightBeat = rightBeat + SUM_W'(rightBit[i]);
      leftBeat  = leftBeat  + SUM_W'(leftBit[i]);
    end
  end

  function automatic logic [CNT_W-1:0] satAdd(input logic [CNT_W-1:0] base,
                                             input logic [SUM_W-1:0] inc);
    logic [CNT_W:0] wide;
    wide = {1'b0, base} + (CNT_W+1)'(inc);
    satAdd = wide[CNT_W] ? CNT_MAX : wide[CNT_W-1:0];
  endfunction

  assign rightBase = ctrl.clear ? '0 : rightCount;
  assign leftBase  = ctrl.clear ? '0 : leftCount;
  assign rightNext = ctrl.accept ? satAdd(rightBase, rightBeat) : rightBase;
  assign leftNext  = ctrl.accept ? satAdd(leftBase, leftBeat) : leftBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rightCount <= '0;
      leftCount  <= '0;
      remap      <= 1'b0;
    end else begin
      if (ctrl.clear || ctrl.accept) begin
        rightCount <= rightNext;
        leftCount  <= leftNext;
      end
      if (ctrl.accept && ctrl.last)
        remap <= rightNext >= threshold;
    end
  end

endmodule

// File: rtl/mlc_refresh_ctrl.sv
module mlc_refresh_ctrl
  import mlc_refresh_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPage,
  input  logic        rawValid,
  input  logic        rawLast,
  input  logic        corValid,
  input  logic        ackDecision,
  output logic        rawReady,
  output logic        corReady,
  output judge_ctrl_t ctrl,
  output logic        done,
  output logic        pending
);
  logic accept;

  assign accept   = rawValid && corValid && !pending;
  assign rawReady = corValid && !pending;
  assign corReady = rawValid && !pending;

  assign ctrl.clear  = startPage;
  assign ctrl.accept = accept;
  assign ctrl.last   = rawLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= accept && rawLast;
      if (accept && rawLast)
        pending <= 1'b1;
      else if (ackDecision)
        pending <= 1'b0;
    end
  end

endmodule

// File: rtl/mlc_refresh_judge.sv
module mlc_refresh_judge
  import mlc_refresh_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CNT_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPage,
  input  logic               rawValid,
  output logic               rawReady,
  input  logic               rawLast,
  input  logic [2*LANES-1:0] rawData,
  input  logic               corValid,
  output logic               corReady,
  input  logic [2*LANES-1:0] corData,
  input  logic [CNT_W-1:0]   threshold,
  input  logic               ackDecision,
  output logic               done,
  output logic               decisionValid,
  output logic               remap,
  output logic [CNT_W-1:0]   rightCount,
  output logic [CNT_W-1:0]   leftCount
);
  judge_ctrl_t ctrl;

  mlc_refresh_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPage(startPage),
    .rawValid(rawValid), .rawLast(rawLast), .corValid(corValid),
    .ackDecision(ackDecision), .rawReady(rawReady), .corReady(corReady),
    .ctrl(ctrl), .done(done), .pending(decisionValid)
  );

  mlc_shift_datapath #(.LANES(LANES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .rawData(rawData),
    .corData(corData), .threshold(threshold),
    .rightCount(rightCount), .leftCount(leftCount), .remap(remap)
  );

endmodule

// File: rtl/mlc_refresh_judge_chk.sv
module mlc_refresh_judge_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPage,
  input logic             rawReady,
  input logic             corReady,
  input logic [CNT_W-1:0] threshold,
  input logic             ackDecision,
  input logic             done,
  input logic             decisionValid,
  input logic             remap,
  input logic [CNT_W-1:0] rightCount,
  input logic [CNT_W-1:0] leftCount
);
  // R6: strobe lasts a single cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: a strobe always comes with a held decision
  a_r6_done_valid: assert property (@(posedge clk) disable iff (!rstN)
    done |-> decisionValid);

  // R6: decision is held until acknowledged
  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid && !ackDecision |=> decisionValid);

  // R8: both streams stalled while a decision is pending
  a_r8_stall: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |-> !rawReady && !corReady);

  // R8: counts and choice frozen while pending
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid && !done |-> $stable(rightCount) && $stable(leftCount) && $stable(remap));

  // R3: without a clear, counts never decrease (no wrap)
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !startPage |=> rightCount >= $past(rightCount) && leftCount >= $past(leftCount));

  // R7: choice matches the right count against the limit seen at acceptance
  a_r7_choice: assert property (@(posedge clk) disable iff (!rstN)
    done |-> remap == (rightCount >= $past(threshold)));

endmodule

bind mlc_refresh_judge mlc_refresh_judge_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .startPage(startPage), .rawReady(rawReady),
  .corReady(corReady), .threshold(threshold), .ackDecision(ackDecision),
  .done(done), .decisionValid(decisionValid), .remap(remap),
  .rightCount(rightCount), .leftCount(leftCount)
);

// File: tb/mlc_refresh_judge_test.sv
module mlc_refresh_judge_test;
  localparam int LANES = 4;
  localparam int CNT_W = 6;
  localparam int W = 2 * LANES;
  localparam int MAXC = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPage = 1'b0, rawValid = 1'b0, rawLast = 1'b0, corValid = 1'b0, ackDecision = 1'b0;
  logic [W-1:0] rawData = '0, corData = '0;
  logic [CNT_W-1:0] threshold = '0;
  logic rawReady, corReady, done, decisionValid, remap;
  logic [CNT_W-1:0] rightCount, leftCount;

  int checks = 0, failures = 0;
  int mRight = 0, mLeft = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mlc_refresh_judge #(.LANES(LANES), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .startPage(startPage), .rawValid(rawValid),
    .rawReady(rawReady), .rawLast(rawLast), .rawData(rawData),
    .corValid(corValid), .corReady(corReady), .corData(corData),
    .threshold(threshold), .ackDecision(ackDecision), .done(done),
    .decisionValid(decisionValid), .remap(remap),
    .rightCount(rightCount), .leftCount(leftCount)
  );

  function automatic int lvl(input logic [1:0] c);
    case (c)
      2'b11: return 0;
      2'b10: return 1;
      2'b01: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one beat through the handshake; model tracks expected counts
  task automatic sendBeat(input logic [W-1:0] r, input logic [W-1:0] c,
                          input logic last, input logic sp);
    int nr, nl;
    @(negedge clk);
    rawData = r; corData = c; rawLast = last; startPage = sp;
    rawValid = 1'b1; corValid = 1'b1;
    #1;
    while (!rawReady) begin @(negedge clk); #1; end
    @(posedge clk);
    #1;
    rawValid = 1'b0; corValid = 1'b0; rawLast = 1'b0; startPage = 1'b0;
    nr = 0; nl = 0;
    for (int i = 0; i < LANES; i++) begin
      if (lvl(r[2*i +: 2]) > lvl(c[2*i +: 2])) nr++;
      if (lvl(r[2*i +: 2]) < lvl(c[2*i +: 2])) nl++;
    end
    if (sp) begin mRight = 0; mLeft = 0; end
    mRight = sat(mRight + nr);
    mLeft  = sat(mLeft + nl);
  endtask

  task automatic clearPage();
    @(negedge clk); startPage = 1'b1;
    @(negedge clk); startPage = 1'b0;
    mRight = 0; mLeft = 0;
    check(rightCount == 0 && leftCount == 0, "R4 clear", int'(rightCount) + int'(leftCount), 0);
  endtask

  // called right after the last beat was sent
  task automatic closePage(input string tag);
    int expRemap;
    expRemap = (mRight >= int'(threshold)) ? 1 : 0;
    @(negedge clk);
    check(done == 1'b1, {"R6 done ", tag}, done, 1);
    check(decisionValid == 1'b1, {"R6 valid ", tag}, decisionValid, 1);
    check(rightCount == CNT_W'(mRight), {"R1 right ", tag}, rightCount, mRight);
    check(leftCount == CNT_W'(mLeft), {"R2 left ", tag}, leftCount, mLeft);
    check(remap == expRemap[0], {"R7 remap ", tag}, remap, expRemap);
    // stall while pending
    rawData = '0; corData = '1; rawValid = 1'b1; corValid = 1'b1;
    @(negedge clk);
    check(done == 1'b0, {"R6 pulse ", tag}, done, 0);
    check(!rawReady && !corReady, {"R8 stall ", tag}, rawReady, 0);
    @(negedge clk);
    check(decisionValid == 1'b1, {"R6 held ", tag}, decisionValid, 1);
    check(rightCount == CNT_W'(mRight) && leftCount == CNT_W'(mLeft),
          {"R8 frozen ", tag}, rightCount, mRight);
    rawValid = 1'b0; corValid = 1'b0;
    ackDecision = 1'b1;
    @(negedge clk);
    ackDecision = 1'b0;
    check(decisionValid == 1'b0, {"R6 ack ", tag}, decisionValid, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(rightCount == 0 && leftCount == 0, "R9 counts", rightCount, 0);
    check(!done && !decisionValid && !remap, "R9 flags", done, 0);

    // R5: one stream valid only -> nothing accepted
    rawValid = 1'b1; rawData = 8'h00; corData = 8'hFF;
    #1;
    check(rawReady == 1'b0 && corReady == 1'b1, "R5 ready", rawReady, 0);
    @(negedge clk);
    check(rightCount == 0, "R5 no accept", rightCount, 0);
    rawValid = 1'b0;

    // directed R1/R2: lane0 00 vs 11 right, lane1 11 vs 10 left,
    // lane2 01 vs 10 right, lane3 equal
    clearPage();
    threshold = 6'd2;
    sendBeat({2'b10, 2'b01, 2'b11, 2'b00}, {2'b10, 2'b10, 2'b10, 2'b11}, 1'b1, 1'b0);
    closePage("dir_remap");
    clearPage();
    threshold = 6'd3;
    sendBeat({2'b10, 2'b01, 2'b11, 2'b00}, {2'b10, 2'b10, 2'b10, 2'b11}, 1'b1, 1'b0);
    closePage("dir_keep");

    // R3 saturation of right count, threshold exactly at ceiling
    clearPage();
    threshold = 6'd63;
    for (int b = 0; b < 20; b++)
      sendBeat(8'h00, 8'hFF, b == 19, 1'b0);
    check(mRight == MAXC, "R3 model", mRight, MAXC);
    closePage("R3_sat_right");

    // R3 left saturation, R7 left shifts do not force a move
    clearPage();
    threshold = 6'd1;
    for (int b = 0; b < 20; b++)
      sendBeat(8'hFF, 8'h00, b == 19, 1'b0);
    closePage("R7_left_only");

    // R4: startPage together with a beat counts only that beat
    sendBeat(8'h00, 8'h55, 1'b0, 1'b0);
    sendBeat({2'b00, 2'b00, 2'b11, 2'b11}, 8'h55, 1'b0, 1'b1);
    @(negedge clk);
    check(rightCount == 2 && leftCount == 2, "R4 clear with beat", rightCount, 2);
    sendBeat(8'hAA, 8'hAA, 1'b1, 1'b0);
    threshold = 6'd2;
    closePage("R4_tail");

    // random pages
    for (int p = 0; p < 40; p++) begin
      int nb;
      nb = 1 + int'($urandom_range(5));
      threshold = CNT_W'($urandom_range(12));
      if (p % 3 == 0) begin
        mRight = 0; mLeft = 0;
      end else
        clearPage();
      for (int b = 0; b < nb; b++) begin
        logic [W-1:0] r, c;
        r = W'($urandom);
        c = ($urandom_range(1) == 0) ? r : W'($urandom);
        sendBeat(r, c, b == nb - 1, (p % 3 == 0) && (b == 0));
      end
      closePage("rand");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule